// File: doc/BRIEF.md
# Cascaded Vectored Priority Interrupt Controller

This block gathers interrupt requests from up to fifteen peripherals, resolves which one should be serviced first, raises one interrupt line towards the processor and, when the processor acknowledges, returns an 8-bit vector that identifies the chosen source. Inside it are two identical eight-line priority units. The secondary unit handles global lines 8 to 15. Its "has a winner" output takes the place of primary input 2, so that input is not available to a device of its own. A device still wired to line 2 is folded onto global line 9.

Each unit keeps an in-service record. A new request can pre-empt the current service only when its primary-level slot has higher priority than every slot already in service. All secondary lines share slot 2, so one secondary source cannot pre-empt another. A one-cycle end-of-service pulse clears the highest-priority source in service. A per-line mask register keeps masked sources out of arbitration.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: During and right after a synchronous reset, `intr`, `vec_valid` and `vec_out` are all 0 and nothing is in service.
- R2: Requests are registered once. `intr` goes high on the second rising edge after an unmasked request appears, provided that request is eligible. A line whose `irq_mask` bit is 1 never raises `intr`.
- R3: Priority order, highest first, is 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7. On the cycle after `inta` is sampled high, `vec_valid` is 1 and `vec_out` equals `VEC_BASE` (default 0x40) plus the winning global line number. At all other times `vec_out` is 0 and `vec_valid` is 0.
- R4: A request on input bit 2 is treated exactly like a request on line 9. Its vector is `VEC_BASE`+9, and `irq_mask` bit 9 gates it. Mask bit 2 has no effect.
- R5: Lines 0, 1 and 3 to 7 use primary slots equal to their own number. Lines 8 to 15 all share primary slot 2. A pending line is eligible only when its slot number is strictly smaller than every slot currently in service. Equal or lower slots wait.
- R6: An acknowledge while a winner exists marks that winner in service: the secondary bit and primary bit 2 for lines 8 to 15, otherwise the primary bit. `intr` is 0 on the cycle after the acknowledge.
- R7: An `eoi` pulse removes the in-service source that ranks highest in the R3 order. Sources that were blocked by it become eligible afterwards.
- R8: An acknowledge with no eligible request produces no vector and changes no in-service state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Level request per global line; bit 2 is redirected to line 9 |
| irq_mask | input | 16 | 1 blocks the corresponding global line |
| inta | input | 1 | One-cycle acknowledge from the processor |
| eoi | input | 1 | One-cycle end-of-service pulse |
| intr | output | 1 | Registered interrupt request to the processor |
| vec_valid | output | 1 | High on the cycle the vector is presented |
| vec_out | output | 8 | Vector, `VEC_BASE` plus line number, zero when idle |

## Verification
The bench builds the block with its default parameters: eight lines per unit, cascade on slot 2, and a vector base of 0x40. With these values every global line, the redirect from line 2 to line 9, and the shared secondary slot can be driven directly from the ports. Random sparse request and mask patterns, interleaved with acknowledges and end-of-service pulses, build up nested in-service stacks several levels deep. Directed sequences cover pre-emption across the cascade slot, blocking between secondary lines, and acknowledges that arrive with nothing eligible.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int UNIT_LINES   = 8;
  localparam int CASCADE_SLOT = 2;
  localparam int TOTAL_LINES  = 2 * UNIT_LINES;
  localparam int LINE_W       = $clog2(TOTAL_LINES);
endpackage

// File: rtl/irq_prio_unit.sv
module irq_prio_unit #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         set_en,
  input  logic         clr_en,
  output logic         has_win,
  output logic [W-1:0] win_idx,
  output logic         top_valid,
  output logic [W-1:0] top_idx,
  output logic [N-1:0] isr
);
  logic [N-1:0] isr_nxt;
  int           limit;

  // highest-priority (lowest index) entry currently in service
  always_comb begin
    top_valid = 1'b0;
    top_idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (isr[i]) begin
        top_valid = 1'b1;
        top_idx   = W'(i);
      end
    end
    limit = top_valid ? int'(top_idx) : N;
  end

  // winner must strictly outrank every in-service entry
  always_comb begin
    has_win = 1'b0;
    win_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && i < limit) begin
        has_win = 1'b1;
        win_idx = W'(i);
      end
    end
  end

  always_comb begin
    isr_nxt = isr;
    if (clr_en && top_valid) isr_nxt[top_idx] = 1'b0;
    if (set_en && has_win)   isr_nxt[win_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) isr <= '0;
    else     isr <= isr_nxt;
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_pkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TOTAL_LINES-1:0] irq_req,
  input  logic [TOTAL_LINES-1:0] irq_mask,
  input  logic                   inta,
  input  logic                   eoi,
  output logic                   intr,
  output logic                   vec_valid,
  output logic [7:0]             vec_out
);
  localparam int UW       = $clog2(UNIT_LINES);
  localparam int REDIR_TO = UNIT_LINES + 1;

  logic [TOTAL_LINES-1:0] req_eff, req_q;
  logic [UNIT_LINES-1:0]  prim_req, prim_isr, sec_isr;
  logic                   p_has_win, p_top_valid, s_has_win, s_top_valid;
  logic [UW-1:0]          p_win, p_top, s_win, s_top;
  logic                   ack_take, win_is_sec;
  logic [LINE_W-1:0]      win_line;

  // fold the legacy cascade input onto its replacement line, then mask
  always_comb begin
    req_eff               = irq_req;
    req_eff[REDIR_TO]     = irq_req[REDIR_TO] | irq_req[CASCADE_SLOT];
    req_eff[CASCADE_SLOT] = 1'b0;
    req_eff               = req_eff & ~irq_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_eff;
  end

  always_comb begin
    prim_req               = req_q[UNIT_LINES-1:0];
    prim_req[CASCADE_SLOT] = s_has_win;
  end

  assign ack_take   = inta && p_has_win;
  assign win_is_sec = (p_win == UW'(CASCADE_SLOT));
  assign win_line   = win_is_sec ? LINE_W'(UNIT_LINES + int'(s_win)) : LINE_W'(p_win);

  irq_prio_unit #(.N(UNIT_LINES)) u_sec (
    .clk      (clk),
    .rst      (rst),
    .req      (req_q[TOTAL_LINES-1:UNIT_LINES]),
    .set_en   (ack_take && win_is_sec),
    .clr_en   (eoi && p_top_valid && p_top == UW'(CASCADE_SLOT)),
    .has_win  (s_has_win),
    .win_idx  (s_win),
    .top_valid(s_top_valid),
    .top_idx  (s_top),
    .isr      (sec_isr)
  );

  irq_prio_unit #(.N(UNIT_LINES)) u_prim (
    .clk      (clk),
    .rst      (rst),
    .req      (prim_req),
    .set_en   (ack_take),
    .clr_en   (eoi),
    .has_win  (p_has_win),
    .win_idx  (p_win),
    .top_valid(p_top_valid),
    .top_idx  (p_top),
    .isr      (prim_isr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      intr      <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      intr      <= inta ? 1'b0 : p_has_win;
      vec_valid <= ack_take;
      vec_out   <= ack_take ? VEC_BASE + 8'(win_line) : 8'h00;
    end
  end
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
  import irq_pkg::*;
#(
  parameter logic [7:0] VEC_BASE = 8'h40
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inta,
  input logic                  intr,
  input logic                  vec_valid,
  input logic [7:0]            vec_out,
  input logic [UNIT_LINES-1:0] p_isr,
  input logic [UNIT_LINES-1:0] s_isr
);
  // R6
  ack_drops_intr_chk: assert property (@(posedge clk) disable iff (rst) inta |=> !intr);
  // R3
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (rst) !vec_valid |-> vec_out == 8'h00);
  // R3
  vec_follows_ack_chk: assert property (@(posedge clk) disable iff (rst) vec_valid |-> $past(inta));
  // R4
  no_cascade_vec_chk: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> vec_out != VEC_BASE + 8'(CASCADE_SLOT));
  // R5
  cascade_link_chk: assert property (@(posedge clk) disable iff (rst) (|s_isr) == p_isr[CASCADE_SLOT]);
  // R5
  sec_single_chk: assert property (@(posedge clk) disable iff (rst) $countones(s_isr) <= 1);
endmodule

bind irq_cascade_ctrl irq_cascade_chk #(.VEC_BASE(VEC_BASE)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inta     (inta),
  .intr     (intr),
  .vec_valid(vec_valid),
  .vec_out  (vec_out),
  .p_isr    (prim_isr),
  .s_isr    (sec_isr)
);

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] BASE = 8'h40;

  logic clk = 1'b0, rst = 1'b1, inta = 1'b0, eoi = 1'b0;
  logic [15:0] irq_req = '0, irq_mask = '0;
  logic intr, vec_valid;
  logic [7:0] vec_out;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_isr = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_cascade_ctrl #(.VEC_BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_mask(irq_mask),
    .inta(inta), .eoi(eoi), .intr(intr), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int slot(int g);
    return (g < 8) ? g : 2;
  endfunction

  function automatic int rank(int g);
    return (g < 2) ? g : (g >= 8) ? g - 6 : g + 7;
  endfunction

  function automatic logic [15:0] eff(logic [15:0] r, logic [15:0] m);
    logic [15:0] e = r;
    e[9] = r[9] | r[2];
    e[2] = 1'b0;
    return e & ~m;
  endfunction

  function automatic int winner(logic [15:0] pend, logic [15:0] isr);
    int minslot = 8;
    int best = -1;
    for (int g = 0; g < 16; g++) if (isr[g] && slot(g) < minslot) minslot = slot(g);
    for (int g = 0; g < 16; g++)
      if (g != 2 && pend[g] && slot(g) < minslot && (best < 0 || rank(g) < rank(best))) best = g;
    return best;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(logic [15:0] r, logic [15:0] m);
    irq_req = r;
    irq_mask = m;
    cyc(3);
  endtask

  // R2 / R5: intr must reflect the model's eligibility
  task automatic chk_intr(string tag);
    int w = winner(eff(irq_req, irq_mask), m_isr);
    chk(intr == (w >= 0), tag, int'(intr), int'(w >= 0));
  endtask

  // R3 / R6 / R8: acknowledge and vector timing
  task automatic ack(string tag, int exp_line);
    int w = winner(eff(irq_req, irq_mask), m_isr);
    inta = 1'b1;
    cyc(1);
    inta = 1'b0;
    if (w >= 0) begin
      chk(vec_valid && vec_out == BASE + 8'(w), tag, vec_out, BASE + w);
      if (exp_line >= 0) chk(w == exp_line, {tag, " model"}, w, exp_line);
      chk(intr == 1'b0, "R6 intr low after ack", intr, 0);
      m_isr[w] = 1'b1;
    end else begin
      chk(!vec_valid && vec_out == 0, tag, vec_out, 0);
    end
    cyc(2);
  endtask

  // R7: drop highest-ranked in-service source
  task automatic end_service();
    int top = -1;
    eoi = 1'b1;
    cyc(1);
    eoi = 1'b0;
    for (int g = 0; g < 16; g++) if (m_isr[g] && (top < 0 || rank(g) < rank(top))) top = g;
    if (top >= 0) m_isr[top] = 1'b0;
    cyc(2);
  endtask

  task automatic drain();
    while (m_isr != 0) end_service();
  endtask

  initial begin
    cyc(1);
    chk(!intr && !vec_valid && vec_out == 0, "R1 in reset", {intr, vec_valid, vec_out}, 0);
    @(negedge clk) rst = 1'b0;
    cyc(2);
    chk(!intr && !vec_valid && vec_out == 0, "R1 after reset", {intr, vec_valid, vec_out}, 0);

    // R4: legacy line redirected to line 9
    set_in(16'h0004, 16'h0000);
    chk(intr == 1'b1, "R2 R4 intr on line 2", intr, 1);
    ack("R4 vector 9", 9);
    end_service();
    set_in(16'h0004, 16'h0200);
    chk(intr == 1'b0, "R4 mask 9 gates line 2", intr, 0);
    set_in(16'h0008, 16'h0008);
    chk(intr == 1'b0, "R2 masked line", intr, 0);
    set_in(16'h0000, 16'h0000);

    // R5: nesting on the primary unit
    set_in(16'h0020, 16'h0000);
    ack("R3 vector 5", 5);
    set_in(16'h0028, 16'h0000);
    chk(intr == 1'b1, "R5 line 3 preempts 5", intr, 1);
    ack("R5 vector 3", 3);
    set_in(16'h0068, 16'h0000);
    chk(intr == 1'b0, "R5 line 6 held off", intr, 0);
    drain();
    set_in(16'h0000, 16'h0000);

    // R5 / R7: shared secondary slot
    set_in(16'h1000, 16'h0000);
    ack("R3 vector 12", 12);
    set_in(16'h1400, 16'h0000);
    chk(intr == 1'b0, "R5 line 10 blocked by 12", intr, 0);
    set_in(16'h1402, 16'h0000);
    chk(intr == 1'b1, "R5 line 1 preempts secondary", intr, 1);
    ack("R5 vector 1", 1);
    irq_req = 16'h1400;
    end_service();
    chk(intr == 1'b0, "R7 first eoi clears 1 only", intr, 0);
    end_service();
    chk(intr == 1'b1, "R7 second eoi frees line 10", intr, 1);
    ack("R7 vector 10", 10);
    drain();

    // R8: acknowledge with nothing eligible
    set_in(16'h0000, 16'h0000);
    ack("R8 spurious ack", -1);
    set_in(16'h0080, 16'h0000);
    chk(intr == 1'b1, "R8 no state after spurious ack", intr, 1);
    ack("R3 vector 7", 7);
    drain();

    // random mix
    void'($urandom(32'h5eed1234));
    for (int it = 0; it < 400; it++) begin
      logic [15:0] r = 16'($urandom & $urandom & $urandom);
      logic [15:0] m = 16'($urandom & $urandom);
      int pick = $urandom % 4;
      set_in(r, m);
      chk_intr("R2 R5 random intr");
      if (pick < 2 && intr) ack("R3 random vector", -1);
      else if (pick == 2 && m_isr != 0) end_service();
      if (!vec_valid) chk(vec_out == 0, "R3 idle vector", vec_out, 0);
    end
    drain();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule